// File: doc/BRIEF.md
# Audio Serial Clock Ratio Checker

This block watches the three clocks of an audio serial input in a device that is clocked from outside: a master clock, a bit clock and a frame clock. All logic runs on the master clock. The bit and frame clocks are brought into that domain through two-flop synchronizers, and their rising edges are detected there. One frame-clock period, from one rising edge to the next, is the measurement window. Within it the block counts master-clock cycles and bit-clock rising edges.

At the end of each window the master-clock count is sorted into one of six ratio classes. The bit-clock count is then checked, first against the two legal values and then against the master-clock class. Faults are recorded in sticky error bits. A ratio is reported as valid only when the measurement is clean and stable across frames. An input flag tells the block when the stream runs at quad speed, which is the only case where the slowest master-clock class is allowed. A watchdog counts master-clock cycles and flags a frame clock that has stopped.

Top module: `clk_ratio_checker`

## Requirements
- R1: Master-clock cycles per frame are encoded on `ratio_code` as 0=64, 1=128, 2=192, 3=256, 4=384, 5=512. A count matches a class when it is within ±2 of that class. A count that matches no class gives code 7 and sets `err_flags[0]`.
- R2: Class 0 (64 per frame) is accepted only while `quad_speed` is 1. With `quad_speed` at 0 that class sets `err_flags[0]` and is never valid.
- R3: For every class except class 0, the number of bit-clock rising edges per frame must be exactly 48 or 64. Any other number sets `err_flags[1]`. At class 0 the bit clock is not measured and has no effect.
- R4: 64 bit-clock edges per frame are legal for every class. 48 edges are legal only at classes 2 and 4. At classes 1, 3 and 5, 48 edges set `err_flags[2]`.
- R5: `ratio_valid` rises only after two consecutive measured frames that are both free of errors, fall in the same class, and have master-clock counts within ±2 of each other. After a faulty frame, one clean frame alone does not raise it.
- R6: When no frame-clock rising edge arrives for `TIMEOUT_CYC` master-clock cycles, the block sets `err_flags[3]` and drops `ratio_valid`. The first frame edge after that only starts a new window.
- R7: Error bits are sticky. A cycle with `clr_we` high clears each bit that has a 1 in `clr_data` and leaves every other bit unchanged.
- R8: After reset, `ratio_code` is 7, `ratio_valid` is 0 and `err_flags` is 0.
- R9: The first frame that breaks R1 to R4 clears `ratio_valid` when its window closes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock; every register uses it |
| rst_n | input | 1 | Active-low asynchronous reset |
| bclk_in | input | 1 | Bit clock, asynchronous to `clk` |
| fclk_in | input | 1 | Frame clock, asynchronous to `clk` |
| quad_speed | input | 1 | 1 while the stream runs at quad speed |
| clr_we | input | 1 | Write strobe for the clear register |
| clr_data | input | 4 | Write-one-to-clear mask for `err_flags` |
| ratio_code | output | 3 | Class of the last measured frame, 7 when it matched none |
| ratio_valid | output | 1 | Class is stable and free of errors |
| err_flags | output | 4 | Sticky errors: [0] master ratio, [1] bit-clock count, [2] bit/master combination, [3] frame clock missing |

## Verification
The hardest conditions to reach from the ports are the edges of the ±2 window and the delay before `ratio_valid` may rise. A count two cycles off must still match its class, and a count three cycles off must not. After a fault, exactly one clean frame must not be enough. The bench produces both bit and frame clocks from a per-frame cycle counter, so every window length is exact and can be set to any integer, including 258, 259, 510 and 515. It also splits a recovery into a run of two frames followed by a run of one frame, and checks `ratio_valid` between the two runs. A stopped frame clock is produced by holding it low past the timeout, then resuming it while clearing a mask that leaves the missing-clock bit set.

// File: rtl/clkratio_pkg.sv
package clkratio_pkg;

    typedef logic [2:0] rcode_t;

    localparam int     NUM_CLASSES = 6;
    localparam rcode_t RC_NONE     = 3'd7;
    localparam rcode_t RC_X64      = 3'd0;
    localparam rcode_t RC_X192     = 3'd2;
    localparam rcode_t RC_X384     = 3'd4;

    localparam int ERR_W       = 4;
    localparam int ERR_MRATIO  = 0;
    localparam int ERR_BCOUNT  = 1;
    localparam int ERR_COMBO   = 2;
    localparam int ERR_NOFRAME = 3;

    localparam int BITS_WIDE   = 64;
    localparam int BITS_NARROW = 48;

    // master-clock cycles per frame for each class code
    function automatic int class_nominal(input int c);
        case (c)
            0:       return 64;
            1:       return 128;
            2:       return 192;
            3:       return 256;
            4:       return 384;
            default: return 512;
        endcase
    endfunction

endpackage

// File: rtl/clkratio_sync.sv
module clkratio_sync #(
    parameter int W = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] async_in,
    output logic [W-1:0] sync_out
);
    logic [W-1:0] meta_q;
    logic [W-1:0] stable_q;

    for (genvar i = 0; i < W; i++) begin : g_bit
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                meta_q[i]   <= 1'b0;
                stable_q[i] <= 1'b0;
            end else begin
                meta_q[i]   <= async_in[i];
                stable_q[i] <= meta_q[i];
            end
        end
    end

    assign sync_out = stable_q;
endmodule

// File: rtl/clkratio_meter.sv
module clkratio_meter #(
    parameter int TIMEOUT_CYC = 1100,
    parameter int CW          = 11
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          fclk_s,
    input  logic          bclk_s,
    output logic          frame_evt,
    output logic [CW-1:0] period,
    output logic [CW-1:0] bcount,
    output logic          timeout_evt
);
    localparam logic [CW-1:0] CNT_MAX = '1;

    typedef struct packed {
        logic          fclk_prev;
        logic          bclk_prev;
        logic [CW-1:0] mcnt;
        logic [CW-1:0] bcnt;
        logic          armed;
        logic          timed_out;
    } meter_t;

    meter_t m_q, m_d;
    logic   f_rise, b_rise;

    always_comb begin
        m_d         = m_q;
        f_rise      = fclk_s & ~m_q.fclk_prev;
        b_rise      = bclk_s & ~m_q.bclk_prev;
        frame_evt   = 1'b0;
        timeout_evt = 1'b0;
        period      = m_q.mcnt + CW'(1);
        bcount      = m_q.bcnt + CW'(b_rise);

        m_d.fclk_prev = fclk_s;
        m_d.bclk_prev = bclk_s;

        if (f_rise) begin
            frame_evt     = m_q.armed;
            m_d.mcnt      = '0;
            m_d.bcnt      = '0;
            m_d.armed     = 1'b1;
            m_d.timed_out = 1'b0;
        end else begin
            if (m_q.mcnt != CNT_MAX) m_d.mcnt = m_q.mcnt + CW'(1);
            if (b_rise && m_q.bcnt != CNT_MAX) m_d.bcnt = m_q.bcnt + CW'(1);
            if (!m_q.timed_out && (int'(m_q.mcnt) + 1 >= TIMEOUT_CYC)) begin
                timeout_evt   = 1'b1;
                m_d.timed_out = 1'b1;
                m_d.armed     = 1'b0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) m_q <= '0;
        else        m_q <= m_d;
    end

    // R6: a measured window never outlasts the watchdog
    assert_window_bound_R6: assert property (@(posedge clk) disable iff (!rst_n)
        frame_evt |-> (int'(period) <= TIMEOUT_CYC));

    // R6: after a timeout the next frame edge only rearms the window
    assert_rearm_after_timeout_R6: assert property (@(posedge clk) disable iff (!rst_n)
        timeout_evt |=> !frame_evt);

    assert_single_event_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !(frame_evt && timeout_evt));
endmodule

// File: rtl/clkratio_judge.sv
module clkratio_judge
    import clkratio_pkg::*;
#(
    parameter int CW        = 11,
    parameter int TOLERANCE = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             frame_evt,
    input  logic [CW-1:0]    period,
    input  logic [CW-1:0]    bcount,
    input  logic             timeout_evt,
    input  logic             quad_speed,
    input  logic             clr_we,
    input  logic [ERR_W-1:0] clr_data,
    output rcode_t           ratio_code,
    output logic             ratio_valid,
    output logic [ERR_W-1:0] err_flags
);
    typedef struct packed {
        rcode_t           code;
        logic             valid;
        logic [ERR_W-1:0] err;
        logic [CW-1:0]    prev_period;
        logic             prev_ok;
    } judge_t;

    judge_t j_q, j_d;

    function automatic rcode_t classify(input logic [CW-1:0] p);
        rcode_t res = RC_NONE;
        for (int c = NUM_CLASSES - 1; c >= 0; c--) begin
            if (int'(p) >= class_nominal(c) - TOLERANCE &&
                int'(p) <= class_nominal(c) + TOLERANCE)
                res = 3'(c);
        end
        return res;
    endfunction

    rcode_t           cls;
    logic             e_mratio, e_bcount, e_combo, frame_ok, close_match;
    logic [ERR_W-1:0] clr_mask;
    int               pdiff;

    always_comb begin
        j_d      = j_q;
        cls      = classify(period);
        clr_mask = clr_we ? clr_data : '0;
        j_d.err  = j_q.err & ~clr_mask;

        e_mratio = (cls == RC_NONE) || (cls == RC_X64 && !quad_speed);
        e_bcount = (cls != RC_X64) &&
                   (bcount != CW'(BITS_WIDE)) && (bcount != CW'(BITS_NARROW));
        e_combo  = (cls != RC_X64) && (cls != RC_NONE) &&
                   (bcount == CW'(BITS_NARROW)) &&
                   (cls != RC_X192) && (cls != RC_X384);
        frame_ok = !(e_mratio || e_bcount || e_combo);

        pdiff       = int'(period) - int'(j_q.prev_period);
        if (pdiff < 0) pdiff = -pdiff;
        close_match = (pdiff <= TOLERANCE) && (cls == j_q.code);

        if (frame_evt) begin
            j_d.code                = cls;
            j_d.valid               = frame_ok && j_q.prev_ok && close_match;
            j_d.prev_ok             = frame_ok;
            j_d.prev_period         = period;
            j_d.err[ERR_MRATIO]     = j_d.err[ERR_MRATIO] | e_mratio;
            j_d.err[ERR_BCOUNT]     = j_d.err[ERR_BCOUNT] | e_bcount;
            j_d.err[ERR_COMBO]      = j_d.err[ERR_COMBO]  | e_combo;
        end
        if (timeout_evt) begin
            j_d.valid             = 1'b0;
            j_d.prev_ok           = 1'b0;
            j_d.err[ERR_NOFRAME]  = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            j_q      <= '0;
            j_q.code <= RC_NONE;
        end else begin
            j_q <= j_d;
        end
    end

    assign ratio_code  = j_q.code;
    assign ratio_valid = j_q.valid;
    assign err_flags   = j_q.err;

    // bits that are set and not addressed by a clear this cycle
    logic [ERR_W-1:0] keep_bits;
    assign keep_bits = j_q.err & ~clr_mask;

    assert_sticky_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((err_flags & $past(keep_bits)) == $past(keep_bits)));

    assert_valid_has_class_R5: assert property (@(posedge clk) disable iff (!rst_n)
        ratio_valid |-> (ratio_code != RC_NONE));

    assert_valid_on_frame_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ratio_valid) |-> $past(frame_evt));

    assert_timeout_flags_R6: assert property (@(posedge clk) disable iff (!rst_n)
        timeout_evt |=> (err_flags[ERR_NOFRAME] && !ratio_valid));

    assert_slow_class_needs_quad_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_evt && classify(period) == RC_X64 && !quad_speed) |=> !ratio_valid);
endmodule

// File: rtl/clk_ratio_checker.sv
module clk_ratio_checker
    import clkratio_pkg::*;
#(
    parameter int TIMEOUT_CYC = 1100,
    parameter int TOLERANCE   = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       bclk_in,
    input  logic       fclk_in,
    input  logic       quad_speed,
    input  logic       clr_we,
    input  logic [3:0] clr_data,
    output logic [2:0] ratio_code,
    output logic       ratio_valid,
    output logic [3:0] err_flags
);
    localparam int CW = $clog2(TIMEOUT_CYC + 2);

    logic [1:0]    sync_v;
    logic          frame_evt, timeout_evt;
    logic [CW-1:0] period, bcount;

    clkratio_sync #(.W(2)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in ({fclk_in, bclk_in}),
        .sync_out (sync_v)
    );

    clkratio_meter #(.TIMEOUT_CYC(TIMEOUT_CYC), .CW(CW)) u_meter (
        .clk         (clk),
        .rst_n       (rst_n),
        .fclk_s      (sync_v[1]),
        .bclk_s      (sync_v[0]),
        .frame_evt   (frame_evt),
        .period      (period),
        .bcount      (bcount),
        .timeout_evt (timeout_evt)
    );

    clkratio_judge #(.CW(CW), .TOLERANCE(TOLERANCE)) u_judge (
        .clk         (clk),
        .rst_n       (rst_n),
        .frame_evt   (frame_evt),
        .period      (period),
        .bcount      (bcount),
        .timeout_evt (timeout_evt),
        .quad_speed  (quad_speed),
        .clr_we      (clr_we),
        .clr_data    (clr_data),
        .ratio_code  (ratio_code),
        .ratio_valid (ratio_valid),
        .err_flags   (err_flags)
    );
endmodule

// File: tb/clk_ratio_checker_tb.sv
module clk_ratio_checker_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bclk_in = 1'b0;
    logic       fclk_in = 1'b0;
    logic       quad_speed = 1'b0;
    logic       clr_we = 1'b0;
    logic [3:0] clr_data = 4'b0;
    logic [2:0] ratio_code;
    logic       ratio_valid;
    logic [3:0] err_flags;

    int checks = 0;
    int failures = 0;
    bit finished = 1'b0;

    always #10 clk = ~clk;

    clk_ratio_checker u_dut (
        .clk(clk), .rst_n(rst_n), .bclk_in(bclk_in), .fclk_in(fclk_in),
        .quad_speed(quad_speed), .clr_we(clr_we), .clr_data(clr_data),
        .ratio_code(ratio_code), .ratio_valid(ratio_valid), .err_flags(err_flags)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int exp_code(input int p);
        int noms[6] = '{64, 128, 192, 256, 384, 512};
        for (int c = 0; c < 6; c++)
            if (p >= noms[c] - 2 && p <= noms[c] + 2) return c;
        return 7;
    endfunction

    // edges the bench actually produces per frame
    function automatic int bits_seen(input int ratio, input int bits);
        return (2 * bits <= ratio) ? bits : 0;
    endfunction

    function automatic int exp_err(input int ratio, input int bits, input bit quad);
        int c = exp_code(ratio);
        int b = bits_seen(ratio, bits);
        int e = 0;
        if (c == 7 || (c == 0 && !quad)) e |= 1;                       // R1 / R2
        if (c != 0 && b != 48 && b != 64) e |= 2;                      // R3
        if (c != 0 && c != 7 && b == 48 && c != 2 && c != 4) e |= 4;   // R4
        return e;
    endfunction

    // frames of `ratio` master cycles with `bits` bit-clock periods each;
    // a clear pulse of `mask` is issued at the start of frame `clr_frame`
    task automatic run_frames(input int ratio, input int bits, input int n,
                              input int clr_frame, input logic [3:0] mask);
        for (int f = 0; f < n; f++) begin
            for (int k = 0; k < ratio; k++) begin
                @(negedge clk);
                fclk_in  = (k < ratio / 2);
                bclk_in  = (2 * bits <= ratio) ? 1'(((k * bits * 2) / ratio) % 2) : 1'b0;
                clr_we   = (f == clr_frame && k == 0);
                clr_data = (f == clr_frame && k == 0) ? mask : 4'b0;
            end
        end
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        if (!finished) begin
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin : main
        int ratios[10] = '{64, 128, 192, 256, 384, 512, 258, 259, 510, 515};
        int bitsv[3]   = '{64, 48, 40};
        repeat (3) @(negedge clk);
        // R8 reset state
        chk("R8 code", int'(ratio_code), 7);
        chk("R8 valid", int'(ratio_valid), 0);
        chk("R8 err", int'(err_flags), 0);
        rst_n = 1'b1;

        // sweep: R1 R2 R3 R4 R5 R9
        for (int q = 0; q < 2; q++) begin
            for (int ri = 0; ri < 10; ri++) begin
                for (int bi = 0; bi < 3; bi++) begin
                    int e;
                    quad_speed = 1'(q);
                    run_frames(ratios[ri], bitsv[bi], 5, 2, 4'b1111);
                    e = exp_err(ratios[ri], bitsv[bi], 1'(q));
                    chk($sformatf("R1 code r=%0d b=%0d", ratios[ri], bitsv[bi]),
                        int'(ratio_code), exp_code(ratios[ri]));
                    chk($sformatf("R2/R3/R4 err r=%0d b=%0d q=%0d", ratios[ri], bitsv[bi], q),
                        int'(err_flags), e);
                    chk($sformatf("R5/R9 valid r=%0d b=%0d q=%0d", ratios[ri], bitsv[bi], q),
                        int'(ratio_valid), (e == 0) ? 1 : 0);
                end
            end
        end

        // R5: one clean frame after a faulty one is not enough
        quad_speed = 1'b0;
        run_frames(300, 64, 3, -1, 4'b0);
        chk("R9 bad frame drops valid", int'(ratio_valid), 0);
        run_frames(256, 64, 2, -1, 4'b0);
        chk("R5 one clean frame", int'(ratio_valid), 0);
        run_frames(256, 64, 1, -1, 4'b0);
        chk("R5 two clean frames", int'(ratio_valid), 1);

        // R7: partial clear leaves other bits set
        run_frames(256, 64, 3, 1, 4'b0010);
        chk("R7 untouched bit stays", int'(err_flags), 1);
        run_frames(256, 64, 3, 1, 4'b0001);
        chk("R7 addressed bit clears", int'(err_flags), 0);

        // R6: stopped frame clock
        @(negedge clk);
        fclk_in = 1'b0;
        repeat (1200) @(negedge clk);
        chk("R6 missing frame flag", int'(err_flags), 8);
        chk("R6 valid dropped", int'(ratio_valid), 0);
        run_frames(256, 64, 2, -1, 4'b0);
        chk("R6 first edge only rearms", int'(ratio_valid), 0);
        run_frames(256, 64, 4, 1, 4'b0111);
        chk("R7 missing bit survives other clears", int'(err_flags), 8);
        chk("R6 recovery valid", int'(ratio_valid), 1);
        run_frames(256, 64, 2, 0, 4'b1000);
        chk("R7 missing bit cleared", int'(err_flags), 0);
        chk("R1 code after recovery", int'(ratio_code), 3);

        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule